// File: doc/BRIEF.md
# Hall Sensor Pattern Filter and Evaluator

This block watches the three position sensors of a brushless motor and decides, after every level change, whether the change was a real commutation step, a wrong step or a short disturbance. The inputs are first brought onto the module clock. Any change of any line restarts a programmable delay. When the delay runs out without a further change, the settled inputs are sampled once and compared with two stored patterns: the pattern the sensors show now, and the pattern the next correct step should produce.

The result is reported as one of three single-cycle pulses. A sample equal to the present pattern means the disturbance has already gone away. A sample equal to the awaited pattern is a valid step, and the awaited pattern then becomes the present one. Any other sample is a fault. Host logic loads both patterns through two write ports. It usually writes the next awaited pattern after each valid step.

Top module: `hall_filter`

## Requirements
- R1: While the synchronized inputs hold their value, the delay counter stays idle and no event pulse is produced. After reset, steady inputs give no events.
- R2: A change of any input line loads the delay counter with the value on `reload`. The counter counts down and the sample is taken when it reaches one. The event pulse is visible after exactly `reload`+3 rising clock edges, counted from the first edge at which the changed input is present.
- R3: A `reload` value of 0 behaves like 1, so the result is visible 4 rising edges after the change.
- R4: A further input change while the delay runs restarts the delay. Exactly one result is produced, timed from the last change, and none appears before it.
- R5: If the sample equals the current pattern, only `evt_spike` pulses. This also holds when the expected pattern has the same value.
- R6: If the sample equals the expected pattern and differs from the current pattern, only `evt_correct` pulses.
- R7: If the sample equals neither stored pattern, only `evt_wrong` pulses.
- R8: On a correct event the expected pattern is copied into the current pattern. The expected pattern changes only through its write port.
- R9: `cur_wr`/`exp_wr` load `cur_wdata`/`exp_wdata` at the next rising edge. Bit i of each pattern is compared with `hall_in[i]`.
- R10: Synchronous active-high reset clears both patterns to 0, clears the synchronizer and the counter, and holds all event outputs low.
- R11: At most one event output is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | module clock, also the sampling clock |
| rst | input | 1 | synchronous active-high reset |
| hall_in | input | 3 | raw sensor lines |
| reload | input | 8 | delay length in clock cycles (0 acts as 1) |
| cur_wr | input | 1 | write strobe for the current pattern |
| cur_wdata | input | 3 | new current pattern |
| exp_wr | input | 1 | write strobe for the expected pattern |
| exp_wdata | input | 3 | new expected pattern |
| evt_spike | output | 1 | pulse: the sample equals the current pattern |
| evt_correct | output | 1 | pulse: the sample equals the expected pattern |
| evt_wrong | output | 1 | pulse: the sample matches neither pattern |

## Verification
The bench uses the default build: three sensor lines, an 8-bit delay counter and a two-stage synchronizer. With three lines, every combination of current pattern, expected pattern and sampled value (512 in all) can be swept. The sweep runs at delays of 0, 1 and 3, so the zero-reload rule, the shortest reload and a normal delay are all timed to the exact cycle. Dedicated sequences cover restarting the delay with a train of glitches, the copy of the expected pattern after a correct step, and the state after reset.

// File: rtl/hall_pkg.sv
package hall_pkg;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_SPIKE   = 2'd1,
    RES_CORRECT = 2'd2,
    RES_WRONG   = 2'd3
  } hall_res_e;

  // Three-way decision; the current-pattern match has priority.
  function automatic hall_res_e classify(input logic hit_cur, input logic hit_exp);
    if (hit_cur)      return RES_SPIKE;
    else if (hit_exp) return RES_CORRECT;
    else              return RES_WRONG;
  endfunction

endpackage

// File: rtl/hall_sync_edge.sv
module hall_sync_edge #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] smp,
  output logic         chg
);
  // pipe[0..STAGES-1] is the synchronizer, pipe[STAGES] the delayed copy
  logic [STAGES:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign smp = pipe[STAGES-1];
  assign chg = |(pipe[STAGES-1] ^ pipe[STAGES]);
endmodule

// File: rtl/hall_delay.sv
module hall_delay #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chg,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt,
  output logic          strobe
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] load_val;
  assign load_val = (reload == '0) ? ONE : reload;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (chg)        cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - ONE;
  end

  // A change in the terminal cycle restarts the delay instead of sampling.
  assign strobe = (cnt == ONE) && !chg;
endmodule

// File: rtl/hall_eval.sv
module hall_eval
  import hall_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] smp,
  input  logic         cur_wr,
  input  logic [W-1:0] cur_wdata,
  input  logic         exp_wr,
  input  logic [W-1:0] exp_wdata,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] exp_q,
  output logic         evt_spike,
  output logic         evt_correct,
  output logic         evt_wrong
);
  hall_res_e res;
  assign res = classify(smp == cur_q, smp == exp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_spike   <= 1'b0;
      evt_correct <= 1'b0;
      evt_wrong   <= 1'b0;
    end else begin
      evt_spike   <= strobe && (res == RES_SPIKE);
      evt_correct <= strobe && (res == RES_CORRECT);
      evt_wrong   <= strobe && (res == RES_WRONG);
    end
  end

  // A host write wins over the copy on a correct step.
  always_ff @(posedge clk) begin
    if (rst)                                   cur_q <= '0;
    else if (cur_wr)                           cur_q <= cur_wdata;
    else if (strobe && (res == RES_CORRECT))   cur_q <= exp_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         exp_q <= '0;
    else if (exp_wr) exp_q <= exp_wdata;
  end
endmodule

// File: rtl/hall_filter.sv
module hall_filter #(
  parameter int W      = 3,
  parameter int CW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  hall_in,
  input  logic [CW-1:0] reload,
  input  logic          cur_wr,
  input  logic [W-1:0]  cur_wdata,
  input  logic          exp_wr,
  input  logic [W-1:0]  exp_wdata,
  output logic          evt_spike,
  output logic          evt_correct,
  output logic          evt_wrong
);
  logic [W-1:0]  smp;
  logic          chg;
  logic [CW-1:0] cnt;
  logic          strobe;
  logic [W-1:0]  cur_q;
  logic [W-1:0]  exp_q;

  hall_sync_edge #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(hall_in), .smp(smp), .chg(chg)
  );

  hall_delay #(.CW(CW)) u_delay (
    .clk(clk), .rst(rst), .chg(chg), .reload(reload), .cnt(cnt), .strobe(strobe)
  );

  hall_eval #(.W(W)) u_eval (
    .clk(clk), .rst(rst), .strobe(strobe), .smp(smp),
    .cur_wr(cur_wr), .cur_wdata(cur_wdata), .exp_wr(exp_wr), .exp_wdata(exp_wdata),
    .cur_q(cur_q), .exp_q(exp_q),
    .evt_spike(evt_spike), .evt_correct(evt_correct), .evt_wrong(evt_wrong)
  );
endmodule

// File: rtl/hall_filter_chk.sv
module hall_filter_chk #(
  parameter int W  = 3,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          chg,
  input logic [CW-1:0] cnt,
  input logic          strobe,
  input logic [CW-1:0] reload,
  input logic          cur_wr,
  input logic          exp_wr,
  input logic [W-1:0]  cur_q,
  input logic [W-1:0]  exp_q,
  input logic          evt_spike,
  input logic          evt_correct,
  input logic          evt_wrong
);
  logic any_evt;
  assign any_evt = evt_spike | evt_correct | evt_wrong;

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !chg) |=> (cnt == '0));

  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    chg |=> (cnt == (($past(reload) == '0) ? CW'(1) : $past(reload))));

  p_evt_src_r2: assert property (@(posedge clk) disable iff (rst)
    any_evt |-> $past(strobe));

  p_copy_r8: assert property (@(posedge clk) disable iff (rst)
    (evt_correct && !$past(cur_wr)) |-> (cur_q == $past(exp_q)));

  p_exp_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(exp_wr) |-> $stable(exp_q));

  p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_spike, evt_correct, evt_wrong}));

  p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    any_evt |=> !any_evt);
endmodule

bind hall_filter hall_filter_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .chg(chg), .cnt(cnt), .strobe(strobe), .reload(reload),
  .cur_wr(cur_wr), .exp_wr(exp_wr), .cur_q(cur_q), .exp_q(exp_q),
  .evt_spike(evt_spike), .evt_correct(evt_correct), .evt_wrong(evt_wrong)
);

// File: tb/hall_filter_tb.sv
module hall_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 3;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  hall_in = '0;
  logic [CW-1:0] reload = '0;
  logic          cur_wr = 1'b0;
  logic [W-1:0]  cur_wdata = '0;
  logic          exp_wr = 1'b0;
  logic [W-1:0]  exp_wdata = '0;
  logic          evt_spike, evt_correct, evt_wrong;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hall_filter #(.W(W), .CW(CW), .STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .hall_in(hall_in), .reload(reload),
    .cur_wr(cur_wr), .cur_wdata(cur_wdata), .exp_wr(exp_wr), .exp_wdata(exp_wdata),
    .evt_spike(evt_spike), .evt_correct(evt_correct), .evt_wrong(evt_wrong)
  );

  // output code: {wrong, correct, spike}
  localparam logic [2:0] K_NONE = 3'b000, K_SPIKE = 3'b001, K_CORR = 3'b010, K_WRONG = 3'b100;

  function automatic logic [2:0] expect_kind(input logic [W-1:0] c, input logic [W-1:0] e,
                                             input logic [W-1:0] s);
    if (s == c)      return K_SPIKE;
    else if (s == e) return K_CORR;
    else             return K_WRONG;
  endfunction

  // Sample each cycle 1 time unit after the edge; expect kind at edge number tgt only.
  task automatic observe(input int tgt, input int span, input logic [2:0] kind, input string tag);
    bit bad = 1'b0;
    logic [2:0] got_bad = '0;
    logic [2:0] exp_bad = '0;
    int at = 0;
    for (int k = 1; k <= span; k++) begin
      logic [2:0] got;
      logic [2:0] want;
      @(posedge clk); #1;
      got  = {evt_wrong, evt_correct, evt_spike};
      want = (k == tgt) ? kind : K_NONE;
      if (got !== want && !bad) begin
        bad = 1'b1; got_bad = got; exp_bad = want; at = k;
      end
    end
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s edge %0d: actual=%b expected=%b", tag, at, got_bad, exp_bad);
    end
  endtask

  // Optional pattern write, then a one-cycle excursion to s^1 and a settle on s.
  task automatic run_case(input bit do_wr, input logic [W-1:0] c, input logic [W-1:0] e,
                          input logic [W-1:0] s, input int n, input logic [2:0] kind,
                          input string tag);
    int d;
    d = (n == 0) ? 1 : n;
    @(negedge clk);
    reload = CW'(n);
    if (do_wr) begin
      cur_wr = 1'b1; cur_wdata = c; exp_wr = 1'b1; exp_wdata = e;
    end
    @(negedge clk);
    cur_wr = 1'b0; exp_wr = 1'b0;
    hall_in = s ^ 3'b001;
    @(negedge clk);
    hall_in = s;
    observe(d + 3, d + 8, kind, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: outputs low during reset
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({evt_wrong, evt_correct, evt_spike} !== 3'b000) begin
      errors++;
      $display("FAIL R10 in reset: actual=%b expected=000", {evt_wrong, evt_correct, evt_spike});
    end
    @(negedge clk); rst = 1'b0;

    // R1 / R10: steady inputs after reset give no event
    reload = 8'd2;
    observe(-1, 30, K_NONE, "R1 steady after reset");

    // R10: patterns reset to zero, so sample 0 is a spike (no writes)
    run_case(1'b0, '0, '0, 3'd0, 2, K_SPIKE, "R10 reset patterns zero");

    // R5 R6 R7 R9 R2 R3: exhaustive sweep of current, expected, sample
    for (int ni = 0; ni < 3; ni++) begin
      int n;
      n = (ni == 0) ? 0 : (ni == 1) ? 1 : 3;
      for (int c = 0; c < 8; c++)
        for (int e = 0; e < 8; e++)
          for (int s = 0; s < 8; s++) begin
            logic [2:0] k;
            k = expect_kind(W'(c), W'(e), W'(s));
            run_case(1'b1, W'(c), W'(e), W'(s), n, k,
                     (k == K_SPIKE) ? "R5 R9 R2 R3 spike" :
                     (k == K_CORR)  ? "R6 R9 R2 R3 correct" : "R7 R9 R2 R3 wrong");
          end
    end

    // R2: a longer delay
    run_case(1'b1, 3'd1, 3'd3, 3'd3, 20, K_CORR, "R2 reload 20");

    // R8: copy of expected into current, expected unchanged
    run_case(1'b1, 3'd1, 3'd3, 3'd3, 2, K_CORR,  "R8 correct step");
    run_case(1'b0, 3'd0, 3'd0, 3'd3, 2, K_SPIKE, "R8 current now holds old expected");
    run_case(1'b0, 3'd0, 3'd0, 3'd1, 2, K_WRONG, "R8 old current gone");
    @(negedge clk); exp_wr = 1'b1; exp_wdata = 3'd2;
    @(negedge clk); exp_wr = 1'b0;
    run_case(1'b0, 3'd0, 3'd0, 3'd2, 2, K_CORR,  "R8 R9 expected only via write");

    // R4: glitch train restarts the delay each time
    @(negedge clk);
    reload = 8'd6;
    cur_wr = 1'b1; cur_wdata = 3'd0; exp_wr = 1'b1; exp_wdata = 3'd5;
    @(negedge clk);
    cur_wr = 1'b0; exp_wr = 1'b0;
    for (int g = 0; g < 4; g++) begin
      hall_in = (g % 2 == 0) ? 3'd4 : 3'd1;
      observe(-1, 3, K_NONE, "R4 no event during glitch train");
      @(negedge clk);
      hall_in = hall_in;
    end
    hall_in = 3'd5;
    observe(6 + 3, 6 + 8, K_CORR, "R4 single result after last change");

    // R4: a burst that returns to the current pattern is a spike
    @(negedge clk); reload = 8'd5;
    hall_in = 3'd2;
    @(negedge clk); hall_in = 3'd5;
    observe(5 + 3, 5 + 8, K_SPIKE, "R4 R5 burst returns to current");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule